// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block is the device-side end of a three-wire serial programming link. While the active-low session input `rstN` is held low, an external programmer clocks 32-bit instructions in on `mosi` with `sck`, and reads results back on `miso`. The block oversamples `sck` and `mosi` with its own CPU clock, assembles the instructions and acts on them against two small internal arrays. One is a word-organised program store, kept as a low and a high byte lane. The other is a byte-organised data store.

Nothing except the enable instruction has any effect until that instruction has been received in the current session. The enable instruction answers with an echo that lets the programmer confirm that it is bit-aligned. After that, the programmer can erase both arrays, write single bytes into either array and read bytes back for verify. Every write and erase is self-timed: a busy flag is held for a fixed number of CPU cycles, and any further write or erase that arrives during that time is thrown away. A static input selects how long each `sck` level must be held at minimum, and any shorter level raises a one-cycle flag.

Top module: `isp_serial_slave`

## Requirements
- R1: While `rstN` is high, `miso`, `busy`, `progEnabled` and `timingViol` are low from the next clock edge onward, and `sck` activity has no effect.
- R2: An instruction whose first two bytes are 0xAC 0x53 sets `progEnabled` when its last bit arrives. If the second byte is 0x53, that value is shifted out on `miso` during the third byte. With any other second byte, the third byte shifts out as 0x00 and `progEnabled` stays low.
- R3: Until `progEnabled` is set, every other instruction is ignored: `busy` stays low, no array changes, and read data shifts out as 0x00.
- R4: Chip erase (0xAC 0x80 xx xx) sets every byte of both arrays to 0xFF by the time `busy` falls.
- R5: Opcode 0x40 writes the fourth byte into the low lane and 0x48 into the high lane of program word {byte2,byte3}. Opcodes 0x20 and 0x28 return those lanes in the fourth byte. Address bits above log2(PROG_WORDS) are ignored.
- R6: Opcode 0xC0 writes the fourth byte to data location {byte2,byte3} and 0xA0 returns it in the fourth byte. Address bits above log2(DATA_BYTES) are ignored. A write replaces the old content outright, with no prior erase needed.
- R7: While a data write is busy, its target location reads 0xFF. The new value is present once `busy` falls.
- R8: An accepted write or erase holds `busy` high for exactly BUSY_CYCLES consecutive clock cycles, starting just after its last bit is received.
- R9: A write or erase instruction that completes while `busy` is high is dropped and changes nothing.
- R10: Raising `rstN` clears `progEnabled` and `busy` and discards a write that has not yet completed.
- R11: With `fastClk` low, an `sck` level held for fewer than SLOW_MIN_PHASE (3) CPU cycles pulses `timingViol` for one cycle. With `fastClk` high the limit is FAST_MIN_PHASE (4). The level in force before the first edge of a session is not checked.
- R12: `mosi` is sampled on each synchronized `sck` rising edge. `miso` changes only after a synchronized `sck` falling edge, and every byte is sent most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock used to oversample the serial bus |
| rstN | input | 1 | Active-low session enable; high aborts and clears the session |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| fastClk | input | 1 | Static: 1 selects the longer minimum `sck` level |
| miso | output | 1 | Serial data to the programmer |
| busy | output | 1 | Self-timed write or erase in progress |
| progEnabled | output | 1 | Enable instruction accepted in this session |
| timingViol | output | 1 | One-cycle pulse when an `sck` level was too short |

## Verification
On every cycle the assertions check the following. The outputs are cleared after the session input rises, busy only ever follows a completed instruction and implies an enabled session, and the enabled state never drops within a session. They also check that `miso` moves only after a detected falling edge and that a violation flag follows a detected edge. Only the bench scenarios can show the content-level behaviour. This covers the erase pattern, the lane and address aliasing of reads and writes, the 0xFF seen during a data write, and the loss of a write dropped while busy or cut short by reset. It also covers the exact busy length and which phase lengths each timing rule accepts.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam logic [7:0] OPC_SYNC     = 8'hAC;
  localparam logic [7:0] OPC_ENABLE   = 8'h53;
  localparam logic [7:0] OPC_ERASE    = 8'h80;
  localparam logic [7:0] OPC_WR_LO    = 8'h40;
  localparam logic [7:0] OPC_WR_HI    = 8'h48;
  localparam logic [7:0] OPC_RD_LO    = 8'h20;
  localparam logic [7:0] OPC_RD_HI    = 8'h28;
  localparam logic [7:0] OPC_WR_DATA  = 8'hC0;
  localparam logic [7:0] OPC_RD_DATA  = 8'hA0;

  typedef enum logic [2:0] {
    TX_ZERO, TX_ECHO, TX_PROG_LO, TX_PROG_HI, TX_DATA
  } txSel_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_ERASE, OP_PROG_LO, OP_PROG_HI, OP_DATA
  } wrOp_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic        loadTx;
    txSel_e      txSel;
    logic [7:0]  echoByte;
    logic [15:0] rdAddr;
    logic        commit;
    logic        preErase;
    wrOp_e       wrOp;
    logic [15:0] wrAddr;
    logic [7:0]  wrData;
  } ctlStrobes_t;

  // Datapath -> control bus events
  typedef struct packed {
    logic       rise;
    logic       fall;
    logic       byteDone;
    logic [7:0] rxByte;
  } busEvents_t;

endpackage

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
#(
  parameter int PROG_WORDS     = 16,
  parameter int DATA_BYTES     = 16,
  parameter int SLOW_MIN_PHASE = 3,
  parameter int FAST_MIN_PHASE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sck,
  input  logic        mosi,
  input  logic        fastClk,
  input  ctlStrobes_t ctl,
  output busEvents_t  ev,
  output logic        miso,
  output logic        timingViol
);

  localparam int PAW = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1;
  localparam int DAW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam int PCW = $clog2(FAST_MIN_PHASE + 2);
  localparam logic [PCW-1:0] PC_MAX = '1;

  // Two-flop synchronizers plus one history stage on SCK
  logic [2:0] sckPipe;
  logic [1:0] mosiPipe;
  logic [2:0] bitCnt;
  logic [7:0] rxShift;
  logic [7:0] txReg;
  logic       misoReg;
  logic [PCW-1:0] phaseCnt;
  logic       seenEdge;
  logic       violReg;

  logic sckRise, sckFall, sckEdge;
  assign sckRise = sckPipe[1] & ~sckPipe[2];
  assign sckFall = ~sckPipe[1] & sckPipe[2];
  assign sckEdge = sckRise | sckFall;

  assign ev.rise     = sckRise;
  assign ev.fall     = sckFall;
  assign ev.byteDone = sckRise && (bitCnt == 3'd7);
  assign ev.rxByte   = {rxShift[6:0], mosiPipe[1]};

  logic [PCW-1:0] minPhase;
  assign minPhase = fastClk ? PCW'(FAST_MIN_PHASE) : PCW'(SLOW_MIN_PHASE);

  always_ff @(posedge clk) begin
    if (rstN) begin
      sckPipe  <= '0;
      mosiPipe <= '0;
      bitCnt   <= '0;
      rxShift  <= '0;
      phaseCnt <= '0;
      seenEdge <= 1'b0;
      violReg  <= 1'b0;
    end else begin
      sckPipe  <= {sckPipe[1:0], sck};
      mosiPipe <= {mosiPipe[0], mosi};
      if (sckRise) begin
        rxShift <= ev.rxByte;
        bitCnt  <= bitCnt + 3'd1;
      end
      violReg <= sckEdge && seenEdge && (phaseCnt < minPhase);
      if (sckEdge) begin
        phaseCnt <= PCW'(1);
        seenEdge <= 1'b1;
      end else if (phaseCnt != PC_MAX) begin
        phaseCnt <= phaseCnt + PCW'(1);
      end
    end
  end

  // Program array: one storage lane per byte of the word
  logic [1:0][7:0] laneRd;
  logic [PAW-1:0]  progRdA, progWrA;
  assign progRdA = ctl.rdAddr[PAW-1:0];
  assign progWrA = ctl.wrAddr[PAW-1:0];

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic [7:0] laneMem [PROG_WORDS];
    wrOp_e laneOp;
    assign laneOp = (lane == 0) ? OP_PROG_LO : OP_PROG_HI;
    always_ff @(posedge clk) begin
      if (ctl.commit && ctl.wrOp == OP_ERASE) begin
        for (int i = 0; i < PROG_WORDS; i++) laneMem[i] <= 8'hFF;
      end else if (ctl.commit && ctl.wrOp == laneOp) begin
        laneMem[progWrA] <= ctl.wrData;
      end
    end
    assign laneRd[lane] = laneMem[progRdA];
  end

  // Data array with erase-then-write sequencing
  logic [7:0]     dataMem [DATA_BYTES];
  logic [DAW-1:0] dataRdA, dataWrA;
  assign dataRdA = ctl.rdAddr[DAW-1:0];
  assign dataWrA = ctl.wrAddr[DAW-1:0];

  always_ff @(posedge clk) begin
    if (ctl.commit && ctl.wrOp == OP_ERASE) begin
      for (int i = 0; i < DATA_BYTES; i++) dataMem[i] <= 8'hFF;
    end else if (ctl.commit && ctl.wrOp == OP_DATA) begin
      dataMem[dataWrA] <= ctl.wrData;
    end else if (ctl.preErase) begin
      dataMem[dataWrA] <= 8'hFF;
    end
  end

  logic [7:0] txMux;
  always_comb begin
    unique case (ctl.txSel)
      TX_ECHO:    txMux = ctl.echoByte;
      TX_PROG_LO: txMux = laneRd[0];
      TX_PROG_HI: txMux = laneRd[1];
      TX_DATA:    txMux = dataMem[dataRdA];
      default:    txMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rstN) begin
      txReg   <= '0;
      misoReg <= 1'b0;
    end else if (ctl.loadTx) begin
      txReg <= txMux;
    end else if (sckFall) begin
      misoReg <= txReg[7];
      txReg   <= {txReg[6:0], 1'b0};
    end
  end

  assign miso       = misoReg;
  assign timingViol = violReg;

  logic unusedAddrBits;
  assign unusedAddrBits = ^{ctl.rdAddr[15:PAW], ctl.wrAddr[15:PAW],
                            ctl.rdAddr[15:DAW], ctl.wrAddr[15:DAW]};

endmodule

// File: rtl/isp_control.sv
module isp_control
  import isp_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  busEvents_t  ev,
  output ctlStrobes_t stb,
  output logic        busy,
  output logic        progEnabled
);

  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  logic [1:0]     byteIdx;
  logic [7:0]     hdr0, hdr1, hdr2;
  logic           enabled;
  logic [BCW-1:0] busyCnt;
  wrOp_e          pendOp;
  logic [15:0]    pendAddr;
  logic [7:0]     pendData;

  wrOp_e newOp;
  logic  enableHit;

  always_comb begin
    stb          = '0;
    stb.loadTx   = ev.byteDone;
    stb.echoByte = ev.rxByte;
    stb.rdAddr   = {hdr1, ev.rxByte};
    newOp        = OP_NONE;
    enableHit    = 1'b0;
    if (ev.byteDone) begin
      unique case (byteIdx)
        2'd1: if (hdr0 == OPC_SYNC && ev.rxByte == OPC_ENABLE) stb.txSel = TX_ECHO;
        2'd2: if (enabled) begin
          unique case (hdr0)
            OPC_RD_LO:   stb.txSel = TX_PROG_LO;
            OPC_RD_HI:   stb.txSel = TX_PROG_HI;
            OPC_RD_DATA: stb.txSel = TX_DATA;
            default:     stb.txSel = TX_ZERO;
          endcase
        end
        2'd3: begin
          enableHit = (hdr0 == OPC_SYNC) && (hdr1 == OPC_ENABLE);
          if (enabled && busyCnt == '0) begin
            unique case (hdr0)
              OPC_SYNC:    if (hdr1 == OPC_ERASE) newOp = OP_ERASE;
              OPC_WR_LO:   newOp = OP_PROG_LO;
              OPC_WR_HI:   newOp = OP_PROG_HI;
              OPC_WR_DATA: newOp = OP_DATA;
              default:     newOp = OP_NONE;
            endcase
          end
        end
        default: ;
      endcase
    end
    stb.commit   = (busyCnt == BCW'(1));
    stb.wrOp     = pendOp;
    stb.wrData   = pendData;
    stb.preErase = (newOp == OP_DATA);
    stb.wrAddr   = stb.preErase ? {hdr1, hdr2} : pendAddr;
  end

  always_ff @(posedge clk) begin
    if (rstN) begin
      byteIdx  <= '0;
      hdr0     <= '0;
      hdr1     <= '0;
      hdr2     <= '0;
      enabled  <= 1'b0;
      busyCnt  <= '0;
      pendOp   <= OP_NONE;
      pendAddr <= '0;
      pendData <= '0;
    end else begin
      if (ev.byteDone) begin
        byteIdx <= byteIdx + 2'd1;
        unique case (byteIdx)
          2'd0: hdr0 <= ev.rxByte;
          2'd1: hdr1 <= ev.rxByte;
          2'd2: hdr2 <= ev.rxByte;
          default: ;
        endcase
      end
      if (enableHit) enabled <= 1'b1;
      if (newOp != OP_NONE) begin
        busyCnt  <= BCW'(BUSY_CYCLES);
        pendOp   <= newOp;
        pendAddr <= {hdr1, hdr2};
        pendData <= ev.rxByte;
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - BCW'(1);
      end
    end
  end

  assign busy        = (busyCnt != '0);
  assign progEnabled = enabled;

  logic unusedEdges;
  assign unusedEdges = ev.rise ^ ev.fall;

endmodule

// File: rtl/isp_serial_slave.sv
module isp_serial_slave
  import isp_pkg::*;
#(
  parameter int PROG_WORDS     = 16,
  parameter int DATA_BYTES     = 16,
  parameter int BUSY_CYCLES    = 1000,
  parameter int SLOW_MIN_PHASE = 3,
  parameter int FAST_MIN_PHASE = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic mosi,
  input  logic fastClk,
  output logic miso,
  output logic busy,
  output logic progEnabled,
  output logic timingViol
);

  busEvents_t  busEv;
  ctlStrobes_t ctlStb;

  isp_datapath #(
    .PROG_WORDS(PROG_WORDS), .DATA_BYTES(DATA_BYTES),
    .SLOW_MIN_PHASE(SLOW_MIN_PHASE), .FAST_MIN_PHASE(FAST_MIN_PHASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .fastClk(fastClk),
    .ctl(ctlStb), .ev(busEv), .miso(miso), .timingViol(timingViol)
  );

  isp_control #(.BUSY_CYCLES(BUSY_CYCLES)) ctl_i (
    .clk(clk), .rstN(rstN), .ev(busEv), .stb(ctlStb),
    .busy(busy), .progEnabled(progEnabled)
  );

endmodule

// File: rtl/isp_serial_slave_chk.sv
module isp_serial_slave_chk (
  input logic clk,
  input logic rstN,
  input logic miso,
  input logic busy,
  input logic progEnabled,
  input logic timingViol,
  input logic evRise,
  input logic evFall,
  input logic evByteDone,
  input logic preErase
);

  logic prevRel = 1'b0;
  always_ff @(posedge clk) prevRel <= rstN;

  AST_IDLE_WHEN_RELEASED: assert property (@(posedge clk)
    prevRel |-> (!busy && !progEnabled && !miso && !timingViol)); // R1

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rstN)
    ($past(progEnabled) && !$past(rstN)) |-> progEnabled); // R2

  AST_BUSY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rstN)
    busy |-> progEnabled); // R3

  AST_BUSY_AFTER_INSTR: assert property (@(posedge clk) disable iff (rstN)
    ($rose(busy) && !$past(rstN)) |-> $past(evByteDone)); // R8

  AST_PREERASE_STARTS_BUSY: assert property (@(posedge clk) disable iff (rstN)
    preErase |=> busy); // R7

  AST_VIOL_ON_EDGE: assert property (@(posedge clk) disable iff (rstN)
    (timingViol && !$past(rstN)) |-> $past(evRise || evFall)); // R11

  AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (rstN)
    ($changed(miso) && !$past(rstN)) |-> $past(evFall)); // R12

endmodule

bind isp_serial_slave isp_serial_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .miso(miso), .busy(busy),
  .progEnabled(progEnabled), .timingViol(timingViol),
  .evRise(busEv.rise), .evFall(busEv.fall), .evByteDone(busEv.byteDone),
  .preErase(ctlStb.preErase)
);

// File: tb/isp_serial_slave_tb_top.sv
module isp_serial_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int DB = 8;
  localparam int BC = 1000;

  logic clk = 1'b0, rstN = 1'b1, sck = 1'b0, mosi = 1'b0, fastClk = 1'b0;
  logic miso, busy, progEnabled, timingViol;

  always #(CLK_PERIOD / 2) clk = ~clk;

  isp_serial_slave #(
    .PROG_WORDS(PW), .DATA_BYTES(DB), .BUSY_CYCLES(BC),
    .SLOW_MIN_PHASE(3), .FAST_MIN_PHASE(4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .fastClk(fastClk),
    .miso(miso), .busy(busy), .progEnabled(progEnabled), .timingViol(timingViol)
  );

  int testsRun = 0, testsFailed = 0;
  int busyRun = 0, lastBusyLen = 0, violCount = 0;
  logic [7:0] progLoM [PW];
  logic [7:0] progHiM [PW];
  logic [7:0] dataM   [DB];

  always @(negedge clk) begin
    if (busy) busyRun++;
    else if (busyRun != 0) begin lastBusyLen = busyRun; busyRun = 0; end
    if (timingViol) violCount++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] b0, b1, b2, b3, input int half,
                      output logic [31:0] resp);
    logic [31:0] word;
    word = {b0, b1, b2, b3};
    resp = '0;
    for (int i = 31; i >= 0; i--) begin
      mosi = word[i];
      repeat (half) @(negedge clk);
      resp = {resp[30:0], miso};
      sck = 1'b1;
      repeat (half) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b0, b1, b2, b3);
    logic [31:0] r;
    xfer(b0, b1, b2, b3, 4, r);
  endtask

  task automatic rd(input logic [7:0] op, ah, al, output logic [7:0] v);
    logic [31:0] r;
    xfer(op, ah, al, 8'h00, 4, r);
    v = r[7:0];
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  v;
    repeat (5) @(negedge clk);
    // R1 reset state and inert bus
    check("R1 miso", miso, 0);
    check("R1 busy", busy, 0);
    check("R1 enabled", progEnabled, 0);
    check("R1 viol", timingViol, 0);
    cmd(8'hAC, 8'h53, 8'h00, 8'h00);
    check("R1 enable ignored while released", progEnabled, 0);

    rstN = 1'b0;
    repeat (5) @(negedge clk);
    // R3 commands before enable are ignored
    cmd(8'hAC, 8'h80, 8'h00, 8'h00);
    check("R3 erase ignored", busy, 0);
    cmd(8'hC0, 8'h00, 8'h01, 8'h55);
    check("R3 data write ignored", busy, 0);
    rd(8'h20, 8'h00, 8'h00, v);
    check("R3 read returns zero", v, 0);

    // R2 enable handshake
    xfer(8'hAC, 8'h54, 8'h00, 8'h00, 4, r);
    check("R2 bad enable no echo", r[15:8], 8'h00);
    check("R2 bad enable not enabled", progEnabled, 0);
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, 4, r);
    check("R2 echo", r[15:8], 8'h53);
    check("R2 enabled", progEnabled, 1);

    // R4 chip erase, R8 busy length
    cmd(8'hAC, 8'h80, 8'h00, 8'h00);
    check("R8 busy after erase", busy, 1);
    waitIdle();
    check("R8 busy length", lastBusyLen, BC);
    for (int a = 0; a < PW; a++) begin
      progLoM[a] = 8'hFF; progHiM[a] = 8'hFF;
      rd(8'h20, 8'h00, 8'(a), v); check("R4 prog lo erased", v, 8'hFF);
      rd(8'h28, 8'h00, 8'(a), v); check("R4 prog hi erased", v, 8'hFF);
    end
    for (int a = 0; a < DB; a++) begin
      dataM[a] = 8'hFF;
      rd(8'hA0, 8'h00, 8'(a), v); check("R4 data erased", v, 8'hFF);
    end

    // R5 R6 write sweep through aliased addresses
    for (int a = 0; a < PW; a++) begin
      progLoM[a] = 8'(a * 37 + 5);
      progHiM[a] = 8'(~(a * 11));
      cmd(8'h40, 8'h30, 8'(a + PW * (a % 3)), progLoM[a]); waitIdle();
      cmd(8'h48, 8'h30, 8'(a + PW * (a % 3)), progHiM[a]); waitIdle();
    end
    for (int a = 0; a < DB; a++) begin
      dataM[a] = 8'(a * 29 + 3);
      cmd(8'hC0, 8'h71, 8'(a + DB * (a % 2)), dataM[a]); waitIdle();
    end
    for (int a = 0; a < PW; a++) begin
      rd(8'h20, 8'h00, 8'(a), v); check("R5 prog lo readback", v, progLoM[a]);
      rd(8'h28, 8'h00, 8'(a), v); check("R5 prog hi readback", v, progHiM[a]);
    end
    for (int a = 0; a < DB; a++) begin
      rd(8'hA0, 8'h00, 8'(a), v); check("R6 data readback", v, dataM[a]);
    end

    // R6 overwrite without erase, R7 erase phase, R9 drop while busy
    cmd(8'hC0, 8'h00, 8'h02, 8'hF0); waitIdle();
    cmd(8'hC0, 8'h00, 8'h02, 8'h0F);
    rd(8'hA0, 8'h00, 8'h02, v);
    check("R7 target reads FF while busy", v, 8'hFF);
    check("R7 still busy", busy, 1);
    cmd(8'hC0, 8'h00, 8'h03, 8'h00);
    check("R9 busy during dropped write", busy, 1);
    waitIdle();
    dataM[2] = 8'h0F;
    rd(8'hA0, 8'h00, 8'h02, v); check("R6 overwrite replaces", v, 8'h0F);
    rd(8'hA0, 8'h00, 8'h03, v); check("R9 dropped write", v, dataM[3]);

    // R10 abort by releasing the session
    cmd(8'h40, 8'h00, 8'h05, 8'h11);
    repeat (20) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 busy cleared", busy, 0);
    check("R10 enable cleared", progEnabled, 0);
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rd(8'h20, 8'h00, 8'h05, v); check("R3 read before re-enable", v, 8'h00);
    cmd(8'hAC, 8'h53, 8'h00, 8'h00);
    rd(8'h20, 8'h00, 8'h05, v); check("R10 aborted write lost", v, progLoM[5]);

    // R11 phase width rules
    check("R11 no violation at 4 cycles slow", violCount, 0);
    fastClk = 1'b1;
    rd(8'hA0, 8'h00, 8'h01, v);
    check("R11 no violation at 4 cycles fast", violCount, 0);
    xfer(8'hA0, 8'h00, 8'h01, 8'h00, 3, r);
    check("R11 fast rule flags 3 cycles", violCount > 0, 1);
    violCount = 0;
    fastClk = 1'b0;
    xfer(8'hA0, 8'h00, 8'h01, 8'h00, 3, r);
    check("R11 slow rule accepts 3 cycles", violCount, 0);
    xfer(8'hA0, 8'h00, 8'h01, 8'h00, 2, r);
    check("R11 slow rule flags 2 cycles", violCount > 0, 1);
    // R12 bit order is exercised by every readback above
    finishRun();
  end

endmodule